// File: doc/BRIEF.md
# Register Window Control Unit

This block tracks which register window a processor thread is using and how many windows it can still move into in each direction. It holds the current window index, the counts of windows free for a save and windows that can be restored, the clean-window count, the count of windows owned by another context, and two 3-bit window-state fields. One of these fields is used for normal traps and the other when other-context windows exist. The block takes save, restore and return requests one per cycle. For each request it either moves the window pointers or returns a trap request that carries a 9-bit trap type. Another unit handles that trap.

A separate write port lets privileged or debug logic load any of these fields. Loading the window index saturates instead of wrapping. The current window index is output so that it can steer a windowed register file. The count outputs let surrounding logic see them. Trap vectoring, moving register contents and instruction decode happen outside this block.

Top module: `regwin_ctrl`

## Requirements
- R1: While reset is asserted, and after it, the window index is 0, the restorable count is 0, the other-context count is 0, the clean count is 0, the save count is NWIN-2, and both window-state fields are 0. No response is pending.
- R2: `req_ack` is high exactly when `req_valid` is high and `wr_en` is low. Each acknowledged request gives `rsp_valid` high in the next cycle. `rsp_tt` is 0 when `rsp_trap` is low. Operation codes: 0 save, 1 restore, 2 return, 3 no-op. A no-op responds without a trap and changes nothing.
- R3: A save with a save count of 0 traps and leaves all state unchanged. With a nonzero other-context count, the type is 0x0A0 OR (other field << 2). Otherwise it is 0x080 OR (normal field << 2).
- R4: A save that does not spill, where the clean count equals the restorable count, traps with type 0x024 and leaves state unchanged.
- R5: A save that does not trap adds one to the window index, subtracts one from the save count and adds one to the restorable count, each modulo NWIN.
- R6: A restore with a restorable count of 0 traps and leaves state unchanged. With a nonzero other-context count, the type is 0x0E0 OR (other field << 2). Otherwise it is 0x0C0 OR (normal field << 2).
- R7: A restore that does not trap subtracts one from the window index, adds one to the save count and subtracts one from the restorable count, each modulo NWIN.
- R8: A return whose target low bits `req_tgt_lo` are not 00 traps with type 0x034 and leaves state unchanged. This check takes priority over the fill check.
- R9: An aligned return applies the fill check of R6 and otherwise updates state as in R7.
- R10: A write loads the field chosen by `wr_sel`: 0 window index, 1 save count, 2 restorable count, 3 clean count, 4 other-context count, 5 window state (normal in `wr_data[2:0]`, other in `wr_data[5:3]`). A count value above NWIN-1 is stored as NWIN-1. Other `wr_sel` codes change nothing.
- R11: A write in the same cycle as a request holds the request off. No acknowledge, no response, and only the write changes state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Window request present |
| req_op | input | 2 | Operation code |
| req_tgt_lo | input | 2 | Low two bits of the return target address |
| req_ack | output | 1 | Request accepted this cycle |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field selector |
| wr_data | input | DW (8) | Write value |
| rsp_valid | output | 1 | Response for the request accepted last cycle |
| rsp_trap | output | 1 | Request raised a trap |
| rsp_tt | output | 9 | Trap type |
| cwp_o | output | log2(NWIN) | Current window index |
| cansave_o | output | log2(NWIN) | Windows available to save |
| canrestore_o | output | log2(NWIN) | Windows available to restore |

## Verification
If a count in this block is wrong, the window index shows it right away: it moves when a trap was due, or it stays put when a move was due. The response one cycle after the offending request carries either a spurious trap type or none. Errors in the other-context count or the window-state fields stay hidden until the next spill or fill. They then show up in bits [4:2] of the trap type or in its base. The stimulus therefore sets each field and forces both trap flavours.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam int TT_W = 9;

  typedef enum logic [1:0] {
    OP_SAVE    = 2'd0,
    OP_RESTORE = 2'd1,
    OP_RETURN  = 2'd2,
    OP_NOP     = 2'd3
  } win_op_e;

  typedef enum logic [2:0] {
    SEL_CWP     = 3'd0,
    SEL_CANSAVE = 3'd1,
    SEL_CANREST = 3'd2,
    SEL_CLEAN   = 3'd3,
    SEL_OTHER   = 3'd4,
    SEL_WSTATE  = 3'd5
  } wr_sel_e;

  typedef enum logic [1:0] {
    MOVE_NONE = 2'd0,
    MOVE_FWD  = 2'd1,
    MOVE_BACK = 2'd2
  } win_move_e;

  localparam logic [TT_W-1:0] TT_SPILL_NORM = 9'h080;
  localparam logic [TT_W-1:0] TT_SPILL_OTH  = 9'h0A0;
  localparam logic [TT_W-1:0] TT_FILL_NORM  = 9'h0C0;
  localparam logic [TT_W-1:0] TT_FILL_OTH   = 9'h0E0;
  localparam logic [TT_W-1:0] TT_CLEAN      = 9'h024;
  localparam logic [TT_W-1:0] TT_MISALIGN   = 9'h034;

endpackage

// File: rtl/regwin_step.sv
// Modulo-NWIN increment or decrement of a window counter.
module regwin_step #(
  parameter int NWIN = 8,
  localparam int IW = $clog2(NWIN)
) (
  input  logic [IW-1:0] val_i,
  input  logic          up_i,
  output logic [IW-1:0] res_o
);

  localparam logic [IW-1:0] TOP = IW'(NWIN - 1);
  localparam logic [IW-1:0] ONE = IW'(1);

  generate
    if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
      // natural wrap of the counter width matches the modulus
      always_comb res_o = up_i ? (val_i + ONE) : (val_i - ONE);
    end else begin : g_general
      always_comb begin
        if (up_i) res_o = (val_i == TOP) ? '0 : (val_i + ONE);
        else      res_o = (val_i == '0) ? TOP : (val_i - ONE);
      end
    end
  endgenerate

endmodule

// File: rtl/regwin_sat.sv
// Clamps a written value into the window counter range.
module regwin_sat #(
  parameter int NWIN = 8,
  parameter int DW   = 8,
  localparam int IW = $clog2(NWIN)
) (
  input  logic [DW-1:0] data_i,
  output logic [IW-1:0] res_o
);

  localparam logic [DW-1:0] LAST_D = DW'(NWIN - 1);
  localparam logic [IW-1:0] LAST_I = IW'(NWIN - 1);

  always_comb res_o = (data_i > LAST_D) ? LAST_I : data_i[IW-1:0];

endmodule

// File: rtl/regwin_decide.sv
// Trap priority and move decision for one window request.
module regwin_decide
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int WSW  = 3,
  localparam int IW = $clog2(NWIN)
) (
  input  win_op_e         op_i,
  input  logic [1:0]      tgt_lo_i,
  input  logic [IW-1:0]   cansave_i,
  input  logic [IW-1:0]   canrest_i,
  input  logic [IW-1:0]   clean_i,
  input  logic [IW-1:0]   other_i,
  input  logic [WSW-1:0]  wst_norm_i,
  input  logic [WSW-1:0]  wst_oth_i,
  output logic            trap_o,
  output logic [TT_W-1:0] tt_o,
  output win_move_e       move_o
);

  logic            use_other;
  logic [TT_W-1:0] field_sh;
  logic [TT_W-1:0] spill_tt;
  logic [TT_W-1:0] fill_tt;
  logic            no_clean;

  always_comb begin
    use_other = (other_i != '0);
    field_sh  = use_other ? TT_W'({wst_oth_i, 2'b00}) : TT_W'({wst_norm_i, 2'b00});
    spill_tt  = (use_other ? TT_SPILL_OTH : TT_SPILL_NORM) | field_sh;
    fill_tt   = (use_other ? TT_FILL_OTH : TT_FILL_NORM) | field_sh;
    no_clean  = (clean_i == canrest_i);
  end

  always_comb begin
    trap_o = 1'b0;
    tt_o   = '0;
    move_o = MOVE_NONE;
    unique case (op_i)
      OP_SAVE: begin
        if (cansave_i == '0) begin
          trap_o = 1'b1;
          tt_o   = spill_tt;
        end else if (no_clean) begin
          trap_o = 1'b1;
          tt_o   = TT_CLEAN;
        end else begin
          move_o = MOVE_FWD;
        end
      end
      OP_RESTORE, OP_RETURN: begin
        if (op_i == OP_RETURN && tgt_lo_i != 2'b00) begin
          trap_o = 1'b1;
          tt_o   = TT_MISALIGN;
        end else if (canrest_i == '0) begin
          trap_o = 1'b1;
          tt_o   = fill_tt;
        end else begin
          move_o = MOVE_BACK;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int WSW  = 3,
  parameter int DW   = 8,
  localparam int IW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [1:0]      req_tgt_lo,
  output logic            req_ack,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [DW-1:0]   wr_data,
  output logic            rsp_valid,
  output logic            rsp_trap,
  output logic [TT_W-1:0] rsp_tt,
  output logic [IW-1:0]   cwp_o,
  output logic [IW-1:0]   cansave_o,
  output logic [IW-1:0]   canrestore_o
);

  localparam logic [IW-1:0] CANSAVE_RST = IW'(NWIN - 2);
  localparam logic [IW-1:0] LAST_I      = IW'(NWIN - 1);
  localparam logic [DW-1:0] LAST_D      = DW'(NWIN - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // state
  logic [IW-1:0]   cwp_q, cansave_q, canrest_q, clean_q, other_q;
  logic [WSW-1:0]  wst_norm_q, wst_oth_q;
  logic [IW-1:0]   cwp_d, cansave_d, canrest_d, clean_d, other_d;
  logic [WSW-1:0]  wst_norm_d, wst_oth_d;
  logic            rsp_valid_q, rsp_trap_q;
  logic [TT_W-1:0] rsp_tt_q;
  logic            rsp_valid_d, rsp_trap_d;
  logic [TT_W-1:0] rsp_tt_d;
  logic            state_en;

  // decision
  logic            dec_trap;
  logic [TT_W-1:0] dec_tt;
  win_move_e       dec_move;
  logic            fwd;
  logic [IW-1:0]   cwp_step, cansave_step, canrest_step;
  logic [IW-1:0]   wr_clamped;

  assign req_ack = req_valid & ~wr_en;
  assign fwd     = (dec_move == MOVE_FWD);

  regwin_decide #(.NWIN(NWIN), .WSW(WSW)) u_decide (
    .op_i       (win_op_e'(req_op)),
    .tgt_lo_i   (req_tgt_lo),
    .cansave_i  (cansave_q),
    .canrest_i  (canrest_q),
    .clean_i    (clean_q),
    .other_i    (other_q),
    .wst_norm_i (wst_norm_q),
    .wst_oth_i  (wst_oth_q),
    .trap_o     (dec_trap),
    .tt_o       (dec_tt),
    .move_o     (dec_move)
  );

  regwin_step #(.NWIN(NWIN)) u_step_cwp (.val_i(cwp_q),     .up_i(fwd),  .res_o(cwp_step));
  regwin_step #(.NWIN(NWIN)) u_step_cs  (.val_i(cansave_q), .up_i(!fwd), .res_o(cansave_step));
  regwin_step #(.NWIN(NWIN)) u_step_cr  (.val_i(canrest_q), .up_i(fwd),  .res_o(canrest_step));

  regwin_sat #(.NWIN(NWIN), .DW(DW)) u_sat (.data_i(wr_data), .res_o(wr_clamped));

  // next state
  always_comb begin
    cwp_d       = cwp_q;
    cansave_d   = cansave_q;
    canrest_d   = canrest_q;
    clean_d     = clean_q;
    other_d     = other_q;
    wst_norm_d  = wst_norm_q;
    wst_oth_d   = wst_oth_q;
    rsp_valid_d = req_ack;
    rsp_trap_d  = req_ack & dec_trap;
    rsp_tt_d    = (req_ack & dec_trap) ? dec_tt : '0;
    state_en    = 1'b0;
    if (wr_en) begin
      state_en = 1'b1;
      unique case (wr_sel_e'(wr_sel))
        SEL_CWP:     cwp_d     = wr_clamped;
        SEL_CANSAVE: cansave_d = wr_clamped;
        SEL_CANREST: canrest_d = wr_clamped;
        SEL_CLEAN:   clean_d   = wr_clamped;
        SEL_OTHER:   other_d   = wr_clamped;
        SEL_WSTATE: begin
          wst_norm_d = wr_data[WSW-1:0];
          wst_oth_d  = wr_data[2*WSW-1:WSW];
        end
        default: state_en = 1'b0;
      endcase
    end else if (req_ack && dec_move != MOVE_NONE) begin
      state_en  = 1'b1;
      cwp_d     = cwp_step;
      cansave_d = cansave_step;
      canrest_d = canrest_step;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cwp_q      <= '0;
      cansave_q  <= CANSAVE_RST;
      canrest_q  <= '0;
      clean_q    <= '0;
      other_q    <= '0;
      wst_norm_q <= '0;
      wst_oth_q  <= '0;
    end else if (state_en) begin
      cwp_q      <= cwp_d;
      cansave_q  <= cansave_d;
      canrest_q  <= canrest_d;
      clean_q    <= clean_d;
      other_q    <= other_d;
      wst_norm_q <= wst_norm_d;
      wst_oth_q  <= wst_oth_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rsp_valid_q <= 1'b0;
      rsp_trap_q  <= 1'b0;
      rsp_tt_q    <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_trap_q  <= rsp_trap_d;
      rsp_tt_q    <= rsp_tt_d;
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_trap     = rsp_trap_q;
  assign rsp_tt       = rsp_tt_q;
  assign cwp_o        = cwp_q;
  assign cansave_o    = cansave_q;
  assign canrestore_o = canrest_q;

  // R2
  ack_rsp_chk: assert property (@(posedge clk) disable iff (!rst_q)
    req_ack |=> rsp_valid);

  // R2
  noack_rsp_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !req_ack |=> !rsp_valid);

  // R3
  spill_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_ack && req_op == OP_SAVE && cansave_q == '0)
      |=> (rsp_trap && $stable(cwp_q) && $stable(canrest_q) && rsp_tt[8:6] == 3'b010));

  // R5
  save_move_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_ack && req_op == OP_SAVE && !rsp_trap_d) |=> !$stable(cwp_q));

  // R8
  misalign_first_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_ack && req_op == OP_RETURN && req_tgt_lo != 2'b00)
      |=> (rsp_tt == TT_MISALIGN && $stable(cwp_q)));

  // R10
  cwp_sat_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && wr_sel == SEL_CWP && wr_data > LAST_D) |=> cwp_q == LAST_I);

  // R11
  wr_holds_req_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && req_valid) |=> !rsp_valid);

endmodule

// File: tb/regwin_ctrl_bench.sv
module regwin_ctrl_bench;

  typedef struct packed {
    logic       wr;
    logic [2:0] code;
    logic [7:0] data;
    logic       trap;
    logic [8:0] tt;
    logic [2:0] cwp;
    logic [2:0] cs;
    logic [2:0] cr;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd0, 8'h00, 1'b1, 9'h024, 3'd0, 3'd6, 3'd0},
    '{1'b1, 3'd3, 8'h07, 1'b0, 9'h000, 3'd0, 3'd6, 3'd0},
    '{1'b0, 3'd0, 8'h00, 1'b0, 9'h000, 3'd1, 3'd5, 3'd1},
    '{1'b0, 3'd0, 8'h00, 1'b0, 9'h000, 3'd2, 3'd4, 3'd2},
    '{1'b0, 3'd1, 8'h00, 1'b0, 9'h000, 3'd1, 3'd5, 3'd1},
    '{1'b0, 3'd2, 8'h01, 1'b1, 9'h034, 3'd1, 3'd5, 3'd1},
    '{1'b0, 3'd2, 8'h00, 1'b0, 9'h000, 3'd0, 3'd6, 3'd0},
    '{1'b0, 3'd1, 8'h00, 1'b1, 9'h0C0, 3'd0, 3'd6, 3'd0},
    '{1'b1, 3'd5, 8'h2B, 1'b0, 9'h000, 3'd0, 3'd6, 3'd0},
    '{1'b0, 3'd1, 8'h00, 1'b1, 9'h0CC, 3'd0, 3'd6, 3'd0},
    '{1'b1, 3'd4, 8'h02, 1'b0, 9'h000, 3'd0, 3'd6, 3'd0},
    '{1'b0, 3'd1, 8'h00, 1'b1, 9'h0F4, 3'd0, 3'd6, 3'd0},
    '{1'b0, 3'd2, 8'h02, 1'b1, 9'h034, 3'd0, 3'd6, 3'd0},
    '{1'b1, 3'd1, 8'h00, 1'b0, 9'h000, 3'd0, 3'd0, 3'd0},
    '{1'b0, 3'd0, 8'h00, 1'b1, 9'h0B4, 3'd0, 3'd0, 3'd0},
    '{1'b1, 3'd4, 8'h00, 1'b0, 9'h000, 3'd0, 3'd0, 3'd0},
    '{1'b0, 3'd0, 8'h00, 1'b1, 9'h08C, 3'd0, 3'd0, 3'd0},
    '{1'b1, 3'd0, 8'd200, 1'b0, 9'h000, 3'd7, 3'd0, 3'd0},
    '{1'b1, 3'd1, 8'h03, 1'b0, 9'h000, 3'd7, 3'd3, 3'd0},
    '{1'b0, 3'd0, 8'h00, 1'b0, 9'h000, 3'd0, 3'd2, 3'd1},
    '{1'b0, 3'd1, 8'h00, 1'b0, 9'h000, 3'd7, 3'd3, 3'd0},
    '{1'b1, 3'd0, 8'h05, 1'b0, 9'h000, 3'd5, 3'd3, 3'd0},
    '{1'b0, 3'd3, 8'h00, 1'b0, 9'h000, 3'd5, 3'd3, 3'd0},
    '{1'b1, 3'd2, 8'h09, 1'b0, 9'h000, 3'd5, 3'd3, 3'd7},
    '{1'b0, 3'd0, 8'h00, 1'b1, 9'h024, 3'd5, 3'd3, 3'd7}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] req_op;
  logic [1:0] req_tgt_lo;
  logic       req_ack;
  logic       wr_en;
  logic [2:0] wr_sel;
  logic [7:0] wr_data;
  logic       rsp_valid;
  logic       rsp_trap;
  logic [8:0] rsp_tt;
  logic [2:0] cwp_o, cansave_o, canrestore_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  regwin_ctrl u_regwin_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_tgt_lo(req_tgt_lo), .req_ack(req_ack),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_tt(rsp_tt),
    .cwp_o(cwp_o), .cansave_o(cansave_o), .canrestore_o(canrestore_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.wr) return "R10";
    if (v.trap) begin
      if (v.tt == 9'h024) return "R4";
      if (v.tt == 9'h034) return "R8";
      if (v.tt[8:6] == 3'b010) return "R3";
      return (v.code == 3'd2) ? "R9" : "R6";
    end
    case (v.code)
      3'd0: return "R5";
      3'd1: return "R7";
      3'd2: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_tgt_lo = 2'd0;
    wr_en = 1'b0; wr_sel = 3'd0; wr_data = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    check("R1 reset state", {rsp_valid, cwp_o, cansave_o, canrestore_o},
          {1'b0, 3'd0, 3'd6, 3'd0});

    for (int i = 0; i < NV; i++) begin
      req_valid  = !VEC[i].wr;
      req_op     = VEC[i].code[1:0];
      req_tgt_lo = VEC[i].data[1:0];
      wr_en      = VEC[i].wr;
      wr_sel     = VEC[i].code;
      wr_data    = VEC[i].data;
      #1;
      check("R2 ack", {31'd0, req_ack}, {31'd0, !VEC[i].wr});
      @(negedge clk);
      check(tag_of(VEC[i]),
            {rsp_valid, rsp_trap, rsp_tt, cwp_o, cansave_o, canrestore_o},
            {!VEC[i].wr, VEC[i].trap, VEC[i].tt, VEC[i].cwp, VEC[i].cs, VEC[i].cr});
    end

    // R11: write and restore together; restore must not be taken
    req_valid = 1'b1; req_op = 2'd1; req_tgt_lo = 2'd0;
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'd2;
    #1;
    check("R11 no ack under write", {31'd0, req_ack}, 32'd0);
    @(negedge clk);
    check("R11 only write applied", {rsp_valid, cwp_o, cansave_o, canrestore_o},
          {1'b0, 3'd2, 3'd3, 3'd7});
    req_valid = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    check("R11 no late response", {31'd0, rsp_valid}, 32'd0);

    // R10: unused selector code changes nothing
    wr_en = 1'b1; wr_sel = 3'd7; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 unused selector", {cwp_o, cansave_o, canrestore_o}, {3'd2, 3'd3, 3'd7});

    // R1: reset mid-run acts at once
    rst_n = 1'b0;
    #1;
    check("R1 async reset", {rsp_valid, cwp_o, cansave_o, canrestore_o},
          {1'b0, 3'd0, 3'd6, 3'd0});
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: clean count back to 0, so a save takes the clean-window trap
    req_valid = 1'b1; req_op = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 clean count reset", {rsp_trap, rsp_tt}, {1'b1, 9'h024});

    done = 1'b1;
    finish_run();
  end

endmodule